// File: doc/BRIEF.md
# Single-Wire Bus Master Slot Engine

This block is the timing engine of a master on a single open-drain data line with a pull-up. A requester issues one operation at a time: a reset cycle that also looks for a presence response, a single write slot, a single read slot, or a search triplet. The engine drives the line low through a pull-down enable and reads the line back through a two-flop synchronizer. It then reports completion with a one-cycle pulse and registered results.

All durations are given in microseconds and multiplied by a clock-ticks-per-microsecond parameter. Each operation therefore takes a fixed number of clock cycles. The search triplet runs two read slots, one for the true bit and one for its complement, followed by one write slot. It reports the two read values, the bit it wrote, a branch flag and a no-device flag. Byte framing is left to the requester.

Top module: `wire_slot_master`

## Requirements
- R1: A reset operation pulls the line low for exactly T_RST_LOW_US×TICKS_PER_US cycles. It then releases the line for a further (T_PRES_SAMPLE_US+T_RST_TAIL_US)×TICKS_PER_US cycles before completion.
- R2: presence_o is updated at the completion of each reset operation. It is 1 when the synchronized line was low at T_PRES_SAMPLE_US after the release, and 0 otherwise.
- R3: A write slot lasts T_SLOT_US×TICKS_PER_US cycles. It pulls the line low for T_SHORT_LOW_US×TICKS_PER_US cycles when the bit is 1 and for T_W0_LOW_US×TICKS_PER_US cycles when the bit is 0.
- R4: A read slot lasts T_SLOT_US×TICKS_PER_US cycles and pulls the line low for T_SHORT_LOW_US×TICKS_PER_US cycles. rd_bit_o returns the synchronized line level sampled T_RD_SAMPLE_US×TICKS_PER_US cycles after the slot start.
- R5: A triplet (op code 3) runs a read slot for the true bit, then a read slot for the complement, then a write slot, all back to back. When the two reads differ, the bit written is the true bit. rd_bit_o, rd_cmp_o and dir_o report the true bit, the complement and the written bit.
- R6: When both triplet reads are 0, branch_o is set and the bit written is req_bit_i as captured with the request.
- R7: When both triplet reads are 1, nodev_o is set, no write slot is issued, and the operation completes after two slots.
- R8: A request (req_valid_i high) is taken only in a cycle where busy_o is 0. A request presented while busy_o is 1 has no effect on the line or on later operations.
- R9: done_o is a single-cycle pulse in the cycle after the last slot ends. busy_o is high from the cycle after acceptance until that last slot ends, and falls in the same cycle that done_o rises.
- R10: After reset, and whenever busy_o is 0, drive_low_o is 0. All result outputs reset to 0.
- R11: No continuous low drive exceeds T_RST_LOW_US×TICKS_PER_US cycles.
- R12: branch_o and nodev_o are cleared when any new request is accepted. After a read or write operation completes, both read 0.
- R13: Op codes on req_op_i are 0 for reset, 1 for write, 2 for read and 3 for triplet. Slots of one operation follow each other with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when busy_o is 0 |
| req_op_i | input | 2 | Operation code (0 reset, 1 write, 2 read, 3 triplet) |
| req_bit_i | input | 1 | Bit to write, or preferred direction at a triplet branch |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| presence_o | output | 1 | Presence seen in the last reset operation |
| rd_bit_o | output | 1 | Bit read (true bit for triplet) |
| rd_cmp_o | output | 1 | Complement bit read by the last triplet |
| dir_o | output | 1 | Bit written by the last triplet |
| branch_o | output | 1 | Both triplet reads were 0 |
| nodev_o | output | 1 | Both triplet reads were 1 |
| line_i | input | 1 | Sensed line level (asynchronous) |
| drive_low_o | output | 1 | Pull-down enable for the open-drain line |

## Verification
The bench builds the engine with TICKS_PER_US set to 2 and keeps every microsecond parameter at its default. At that scale a full reset cycle takes 1920 clocks and a slot takes 140. This lets the bench's reference model follow the pull-down level and busy and done flags on every clock for every slot shape. A responder in the bench answers reset cycles and read slots through the wired line, which exercises the sample points through the synchronizer lag. It covers all four triplet outcomes and a request injected mid-operation.

// File: rtl/wsm_pkg.sv
package wsm_pkg;
  typedef enum logic [1:0] {
    OP_RESET   = 2'd0,
    OP_WRITE   = 2'd1,
    OP_READ    = 2'd2,
    OP_TRIPLET = 2'd3
  } wsm_op_e;

  typedef enum logic [1:0] {
    SK_RESET = 2'd0,
    SK_WRITE = 2'd1,
    SK_READ  = 2'd2
  } slot_kind_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SINGLE,
    SQ_TRI_A,
    SQ_TRI_B,
    SQ_TRI_C
  } seq_state_e;
endpackage

// File: rtl/wsm_sync.sv
module wsm_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= RESET_VAL;
        else         sr_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= {STAGES{RESET_VAL}};
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/wsm_slot.sv
module wsm_slot
  import wsm_pkg::*;
#(
  parameter int TICKS_PER_US     = 10,
  parameter int T_RST_LOW_US     = 480,
  parameter int T_PRES_SAMPLE_US = 70,
  parameter int T_RST_TAIL_US    = 410,
  parameter int T_SHORT_LOW_US   = 6,
  parameter int T_W0_LOW_US      = 65,
  parameter int T_RD_SAMPLE_US   = 13,
  parameter int T_SLOT_US        = 70
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  slot_kind_e kind_i,
  input  logic       wbit_i,
  input  logic       line_i,
  output logic       drive_low_o,
  output logic       fin_o,
  output logic       sample_o
);
  localparam int RST_END_I = (T_RST_LOW_US + T_PRES_SAMPLE_US + T_RST_TAIL_US) * TICKS_PER_US;
  localparam int SLOT_I    = T_SLOT_US * TICKS_PER_US;
  localparam int CNT_TOP   = (RST_END_I > SLOT_I) ? RST_END_I : SLOT_I;
  localparam int CW        = $clog2(CNT_TOP + 1);

  localparam logic [CW-1:0] RST_LOW_C   = CW'(T_RST_LOW_US * TICKS_PER_US);
  localparam logic [CW-1:0] PRES_AT_C   = CW'((T_RST_LOW_US + T_PRES_SAMPLE_US) * TICKS_PER_US);
  localparam logic [CW-1:0] RST_LAST_C  = CW'(RST_END_I - 1);
  localparam logic [CW-1:0] SHORT_C     = CW'(T_SHORT_LOW_US * TICKS_PER_US);
  localparam logic [CW-1:0] W0_C        = CW'(T_W0_LOW_US * TICKS_PER_US);
  localparam logic [CW-1:0] RD_AT_C     = CW'(T_RD_SAMPLE_US * TICKS_PER_US);
  localparam logic [CW-1:0] SLOT_LAST_C = CW'(SLOT_I - 1);

  logic          active_q;
  logic [CW-1:0] cnt_q;
  slot_kind_e    kind_q;
  logic          wbit_q;
  logic          sample_q;

  logic [CW-1:0] low_end, samp_at, last_at;
  logic          samp_en;

  always_comb begin
    unique case (kind_q)
      SK_RESET: begin
        low_end = RST_LOW_C;
        samp_at = PRES_AT_C;
        last_at = RST_LAST_C;
        samp_en = 1'b1;
      end
      SK_READ: begin
        low_end = SHORT_C;
        samp_at = RD_AT_C;
        last_at = SLOT_LAST_C;
        samp_en = 1'b1;
      end
      default: begin
        low_end = wbit_q ? SHORT_C : W0_C;
        samp_at = '0;
        last_at = SLOT_LAST_C;
        samp_en = 1'b0;
      end
    endcase
  end

  assign drive_low_o = active_q && (cnt_q < low_end);
  assign fin_o       = active_q && (cnt_q == last_at);
  assign sample_o    = sample_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      kind_q   <= SK_WRITE;
      wbit_q   <= 1'b1;
      sample_q <= 1'b1;
    end else begin
      if (start_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        kind_q   <= kind_i;
        wbit_q   <= wbit_i;
      end else if (fin_o) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else if (active_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (active_q && samp_en && (cnt_q == samp_at)) sample_q <= line_i;
    end
  end
endmodule

// File: rtl/wire_slot_master.sv
module wire_slot_master
  import wsm_pkg::*;
#(
  parameter int TICKS_PER_US     = 10,
  parameter int T_RST_LOW_US     = 480,
  parameter int T_PRES_SAMPLE_US = 70,
  parameter int T_RST_TAIL_US    = 410,
  parameter int T_SHORT_LOW_US   = 6,
  parameter int T_W0_LOW_US      = 65,
  parameter int T_RD_SAMPLE_US   = 13,
  parameter int T_SLOT_US        = 70,
  parameter int SYNC_STAGES      = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic [1:0] req_op_i,
  input  logic       req_bit_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       presence_o,
  output logic       rd_bit_o,
  output logic       rd_cmp_o,
  output logic       dir_o,
  output logic       branch_o,
  output logic       nodev_o,
  input  logic       line_i,
  output logic       drive_low_o
);
  seq_state_e state_q;
  wsm_op_e    op_q, req_op;
  logic       chosen_q, a_q;
  logic       done_q, presence_q, rd_bit_q, rd_cmp_q, dir_q, branch_q, nodev_q;

  logic       line_s;
  logic       slot_start, slot_wbit, slot_fin, slot_sample;
  slot_kind_e slot_kind;
  logic       accept, dir_next, both_one;

  assign req_op   = wsm_op_e'(req_op_i);
  assign accept   = (state_q == SQ_IDLE) && req_valid_i;
  assign both_one = a_q && slot_sample;
  assign dir_next = (a_q ^ slot_sample) ? a_q : chosen_q;

  wsm_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  always_comb begin
    slot_start = 1'b0;
    slot_kind  = SK_READ;
    slot_wbit  = 1'b1;
    if (accept) begin
      slot_start = 1'b1;
      slot_wbit  = req_bit_i;
      unique case (req_op)
        OP_RESET: slot_kind = SK_RESET;
        OP_WRITE: slot_kind = SK_WRITE;
        default:  slot_kind = SK_READ;
      endcase
    end else if (slot_fin && (state_q == SQ_TRI_A)) begin
      slot_start = 1'b1;
    end else if (slot_fin && (state_q == SQ_TRI_B) && !both_one) begin
      slot_start = 1'b1;
      slot_kind  = SK_WRITE;
      slot_wbit  = dir_next;
    end
  end

  wsm_slot #(
    .TICKS_PER_US    (TICKS_PER_US),
    .T_RST_LOW_US    (T_RST_LOW_US),
    .T_PRES_SAMPLE_US(T_PRES_SAMPLE_US),
    .T_RST_TAIL_US   (T_RST_TAIL_US),
    .T_SHORT_LOW_US  (T_SHORT_LOW_US),
    .T_W0_LOW_US     (T_W0_LOW_US),
    .T_RD_SAMPLE_US  (T_RD_SAMPLE_US),
    .T_SLOT_US       (T_SLOT_US)
  ) u_slot (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (slot_start),
    .kind_i     (slot_kind),
    .wbit_i     (slot_wbit),
    .line_i     (line_s),
    .drive_low_o(drive_low_o),
    .fin_o      (slot_fin),
    .sample_o   (slot_sample)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SQ_IDLE;
      op_q       <= OP_RESET;
      chosen_q   <= 1'b0;
      a_q        <= 1'b0;
      done_q     <= 1'b0;
      presence_q <= 1'b0;
      rd_bit_q   <= 1'b0;
      rd_cmp_q   <= 1'b0;
      dir_q      <= 1'b0;
      branch_q   <= 1'b0;
      nodev_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        SQ_IDLE: if (req_valid_i) begin
          op_q     <= req_op;
          chosen_q <= req_bit_i;
          branch_q <= 1'b0;
          nodev_q  <= 1'b0;
          state_q  <= (req_op == OP_TRIPLET) ? SQ_TRI_A : SQ_SINGLE;
        end
        SQ_SINGLE: if (slot_fin) begin
          state_q <= SQ_IDLE;
          done_q  <= 1'b1;
          if (op_q == OP_RESET) presence_q <= ~slot_sample;
          if (op_q == OP_READ)  rd_bit_q   <= slot_sample;
        end
        SQ_TRI_A: if (slot_fin) begin
          a_q     <= slot_sample;
          state_q <= SQ_TRI_B;
        end
        SQ_TRI_B: if (slot_fin) begin
          rd_bit_q <= a_q;
          rd_cmp_q <= slot_sample;
          branch_q <= ~a_q & ~slot_sample;
          if (both_one) begin
            nodev_q <= 1'b1;
            state_q <= SQ_IDLE;
            done_q  <= 1'b1;
          end else begin
            dir_q   <= dir_next;
            state_q <= SQ_TRI_C;
          end
        end
        SQ_TRI_C: if (slot_fin) begin
          state_q <= SQ_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != SQ_IDLE);
  assign done_o     = done_q;
  assign presence_o = presence_q;
  assign rd_bit_o   = rd_bit_q;
  assign rd_cmp_o   = rd_cmp_q;
  assign dir_o      = dir_q;
  assign branch_o   = branch_q;
  assign nodev_o    = nodev_q;
endmodule

// File: rtl/wsm_checker.sv
module wsm_checker #(
  parameter int MAX_LOW = 4800
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic busy_o,
  input logic done_o,
  input logic branch_o,
  input logic nodev_o,
  input logic drive_low_o
);
  int low_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          low_run <= 0;
    else if (drive_low_o) low_run <= low_run + 1;
    else                  low_run <= 0;
  end

  a_r10_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !drive_low_o);

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_busy_fall_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r9_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r8_start_on_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_valid_i));

  a_r11_low_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_low_o |-> (low_run < MAX_LOW));

  a_r7_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(nodev_o && branch_o));
endmodule

bind wire_slot_master wsm_checker #(
  .MAX_LOW(T_RST_LOW_US * TICKS_PER_US)
) u_wsm_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .branch_o   (branch_o),
  .nodev_o    (nodev_o),
  .drive_low_o(drive_low_o)
);

// File: tb/wire_slot_master_bench.sv
module wire_slot_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int K          = 2;
  localparam int RST_LOW    = 480 * K;
  localparam int RST_TOTAL  = (480 + 70 + 410) * K;
  localparam int SHORT      = 6 * K;
  localparam int W0         = 65 * K;
  localparam int SLOT       = 70 * K;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic req_bit = 1'b0;
  logic busy, done, presence, rd_bit, rd_cmp, dir, branch, nodev, drive_low, line;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // behavioural responder
  bit slave_present = 1'b1;
  bit rsp_q[$];
  int hold = 0;
  int pres_wait = 0;
  int low_len = 0;
  int max_low = 0;
  bit prev_drive = 1'b0;
  logic slave_low = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign line = ~(drive_low | slave_low);

  wire_slot_master #(.TICKS_PER_US(K)) u_wire_slot_master (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_bit_i(req_bit), .busy_o(busy), .done_o(done), .presence_o(presence),
    .rd_bit_o(rd_bit), .rd_cmp_o(rd_cmp), .dir_o(dir), .branch_o(branch),
    .nodev_o(nodev), .line_i(line), .drive_low_o(drive_low)
  );

  always @(negedge clk) begin
    if (drive_low && !prev_drive && rsp_q.size() > 0) begin
      if (!rsp_q.pop_front()) hold = 60;
    end
    if (!drive_low && prev_drive && low_len >= 400 * K && slave_present) pres_wait = 40;
    if (drive_low) low_len = low_len + 1;
    else low_len = 0;
    if (low_len > max_low) max_low = low_len;
    if (pres_wait > 0) begin
      pres_wait = pres_wait - 1;
      if (pres_wait == 0) hold = 200;
    end
    slave_low = (hold > 0);
    if (hold > 0) hold = hold - 1;
    prev_drive = drive_low;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic start_req(input logic [1:0] op, input logic b);
    req_op = op;
    req_bit = b;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // compares pull-down, busy and done on every cycle of one slot
  task automatic run_slot(input int low, input int len, input string req, input bit poke);
    int bad = 0;
    int first_bad_t = -1;
    for (int t = 0; t < len; t++) begin
      if (poke && t == 3) begin
        req_op = 2'd0; req_valid = 1'b1;
      end
      if (poke && t == 4) req_valid = 1'b0;
      if ((drive_low !== (t < low)) || (busy !== 1'b1) || (done !== 1'b0)) begin
        bad++;
        if (first_bad_t < 0) first_bad_t = t;
      end
      @(negedge clk);
    end
    check(bad == 0, req, "slot waveform mismatch cycles (first at offset shown as actual)",
          first_bad_t, -1);
  endtask

  task automatic check_done(input string req);
    check(done === 1'b1 && busy === 1'b0, req, "done pulse with busy low",
          {30'd0, done, busy}, 2);
  endtask

  task automatic do_reset_op(input bit present, input bit exp_pres);
    slave_present = present;
    start_req(2'd0, 1'b0);
    run_slot(RST_LOW, RST_TOTAL, "R1", 1'b0);
    check_done("R9");
    check(presence === exp_pres, "R2", "presence", presence, exp_pres);
    @(negedge clk);
    check(done === 1'b0, "R9", "done width", done, 0);
  endtask

  task automatic do_triplet(input bit a, input bit b, input bit chosen, input bit poke);
    bit expd;
    rsp_q.push_back(a);
    rsp_q.push_back(b);
    start_req(2'd3, chosen);
    run_slot(SHORT, SLOT, "R5", poke);
    run_slot(SHORT, SLOT, "R5", 1'b0);
    if (a && b) begin
      check_done("R7");
      check(nodev === 1'b1 && branch === 1'b0, "R7", "nodev/branch",
            {30'd0, nodev, branch}, 2);
    end else begin
      expd = (a != b) ? a : chosen;
      run_slot(expd ? SHORT : W0, SLOT, (a != b) ? "R5" : "R6", 1'b0);
      check_done("R5");
      check(dir === expd, (a != b) ? "R5" : "R6", "written bit", dir, expd);
      check(branch === (!a && !b), "R6", "branch", branch, !a && !b);
      check(nodev === 1'b0, "R7", "nodev", nodev, 0);
    end
    check(rd_bit === a && rd_cmp === b, "R5", "true/complement",
          {30'd0, rd_bit, rd_cmp}, {30'd0, a, b});
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(drive_low === 1'b0 && busy === 1'b0 && done === 1'b0 && presence === 1'b0,
          "R10", "state in reset", {28'd0, drive_low, busy, done, presence}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(drive_low === 1'b0 && busy === 1'b0, "R10", "idle after reset",
          {30'd0, drive_low, busy}, 0);

    do_reset_op(1'b1, 1'b1);
    do_reset_op(1'b0, 1'b0);
    do_reset_op(1'b1, 1'b1);

    // R3 write slots
    start_req(2'd1, 1'b1);
    run_slot(SHORT, SLOT, "R3", 1'b0);
    check_done("R3");
    @(negedge clk);
    start_req(2'd1, 1'b0);
    run_slot(W0, SLOT, "R3", 1'b0);
    check_done("R3");
    @(negedge clk);

    // R4 read slots
    rsp_q.push_back(1'b0);
    start_req(2'd2, 1'b1);
    run_slot(SHORT, SLOT, "R4", 1'b0);
    check_done("R4");
    check(rd_bit === 1'b0, "R4", "read zero", rd_bit, 0);
    @(negedge clk);
    rsp_q.push_back(1'b1);
    start_req(2'd2, 1'b1);
    run_slot(SHORT, SLOT, "R4", 1'b0);
    check_done("R4");
    check(rd_bit === 1'b1, "R4", "read one", rd_bit, 1);
    @(negedge clk);

    // R5, R6, R7, R13 triplets
    do_triplet(1'b0, 1'b1, 1'b1, 1'b0);
    do_triplet(1'b1, 1'b0, 1'b0, 1'b0);
    do_triplet(1'b0, 1'b0, 1'b1, 1'b0);
    do_triplet(1'b0, 1'b0, 1'b0, 1'b0);
    do_triplet(1'b1, 1'b1, 1'b0, 1'b0);

    // R12: flags cleared by next accepted request
    rsp_q.push_back(1'b1);
    start_req(2'd2, 1'b1);
    run_slot(SHORT, SLOT, "R12", 1'b0);
    check_done("R12");
    check(nodev === 1'b0 && branch === 1'b0, "R12", "flags cleared",
          {30'd0, nodev, branch}, 0);
    @(negedge clk);

    // R8: request while busy ignored
    do_triplet(1'b0, 1'b0, 1'b1, 1'b1);
    repeat (6) begin
      check(busy === 1'b0 && drive_low === 1'b0, "R8", "no op after busy request",
            {30'd0, busy, drive_low}, 0);
      @(negedge clk);
    end

    check(max_low == RST_LOW, "R11", "longest low run", max_low, RST_LOW);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R9 watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule